// File: doc/BRIEF.md
# Chained Self-Checking Stage Pipeline

The block strings a configurable number of registered combinational stages into one pipeline. Every stage holds a data transform, a generator that produces check bits for the transformed word, and a checker. The checker does not judge the stage's own result. It judges the data word and check bits that arrive at the stage's inputs, so each stage watches its predecessor and the wires that lead to it. A final checker sits after the last stage register and covers that stage and the output nets.

Each stage registers its data word and its check bits on the same edge, so every checker sees a matching pair. Stage 0 checks the word that enters the chain, which means it reports on whatever produced that word upstream. Each checker's mismatch is merged into a sticky error register, with one bit per check point. A bit stays set until the clear input is asserted. A fault-injection input can XOR a mask onto each inter-stage link, so on-line detection can be exercised in the system.

Top module: `scc_chain`

## Requirements
- R1: Check bits for a DATA_W-bit word d are defined as follows. Bit 0 is the XOR of all bits of d. Bit k, for 1 <= k < CHK_W, is the XOR of the bits d[i] whose index i has bit (k-1) equal to 1. A word whose check bits match this code raises no error flag.
- R2: Stage s (0-based) computes its output as the input rotated left by one bit, plus (s+1), modulo 2^DATA_W. It registers this result. A word applied at data_i appears at data_o after exactly NUM_STAGES rising clock edges.
- R3: When no injection is applied on the last link, chk_o always equals the R1 code of data_o.
- R4: If chk_i does not equal the R1 code of data_i, err_o bit 0 is set at the next rising edge.
- R5: inj_i is split into one slice per link j, for j = 1..NUM_STAGES. Slice j is bits [(j-1)*(DATA_W+CHK_W) +: DATA_W+CHK_W]. Its low DATA_W bits are XORed onto the data word of link j and its high CHK_W bits onto the check bits of link j. Link j is the output of stage j-1. If the corrupted pair breaks the R1 code, err_o bit j is set at the next edge, and no other err_o bit is set.
- R6: Link NUM_STAGES drives data_o and chk_o and is checked by the final checker, which reports on err_o bit NUM_STAGES.
- R7: A set err_o bit stays set after its fault has gone away, until clr_i is asserted.
- R8: clr_i clears err_o at the next edge. A mismatch present in the same cycle as clr_i is still recorded, so set wins over clear for that bit.
- R9: err_any_o is 1 exactly when at least one err_o bit is set.
- R10: While reset is asserted, err_o, err_any_o, data_o and chk_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | DATA_W | Data word entering the chain |
| chk_i | input | CHK_W | Check bits accompanying data_i |
| inj_i | input | NUM_STAGES*(DATA_W+CHK_W) | Per-link XOR fault masks |
| clr_i | input | 1 | Clears the sticky error register |
| data_o | output | DATA_W | Data word leaving the last stage |
| chk_o | output | CHK_W | Check bits leaving the last stage |
| err_o | output | NUM_STAGES+1 | Sticky per-check-point error flags |
| err_any_o | output | 1 | OR of all error flags |

## Verification
Clearing the error register and detecting a new mismatch can happen in the same cycle. The bench first sets an error bit through an injection on one link. It then asserts clr_i while feeding a check word that breaks the code at the chain input. The test passes when only bit 0 remains set after that edge, which shows the old flag was cleared and the new one was kept. Random injection masks are judged against a bench-computed code, so masks that happen to form a valid codeword are expected to pass without any flag.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned DEF_STAGES = 3;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_CHK_W  = 4;

  // membership of data bit i in check group k
  function automatic logic in_group(input int unsigned k, input int unsigned i);
    if (k == 0) return 1'b1;
    return logic'((i >> (k - 1)) & 1);
  endfunction
endpackage

// File: rtl/scc_chkgen.sv
module scc_chkgen #(
  parameter int unsigned DATA_W = scc_pkg::DEF_DATA_W,
  parameter int unsigned CHK_W  = scc_pkg::DEF_CHK_W
) (
  input  logic [DATA_W-1:0] d_i,
  output logic [CHK_W-1:0]  c_o
);
  always_comb begin
    c_o = '0;
    for (int unsigned k = 0; k < CHK_W; k++) begin
      for (int unsigned i = 0; i < DATA_W; i++) begin
        if (scc_pkg::in_group(k, i)) c_o[k] = c_o[k] ^ d_i[i];
      end
    end
  end
endmodule

// File: rtl/scc_stage.sv
module scc_stage #(
  parameter int unsigned DATA_W = scc_pkg::DEF_DATA_W,
  parameter int unsigned CHK_W  = scc_pkg::DEF_CHK_W,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_d_i,
  input  logic [CHK_W-1:0]  in_c_i,
  output logic              fail_o,
  output logic [DATA_W-1:0] q_d_o,
  output logic [CHK_W-1:0]  q_c_o
);
  logic [CHK_W-1:0]  exp_c;
  logic [DATA_W-1:0] fn_d;
  logic [CHK_W-1:0]  fn_c;

  // checker on the incoming pair (judges the predecessor)
  scc_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_in_chk (.d_i(in_d_i), .c_o(exp_c));
  assign fail_o = (exp_c != in_c_i);

  assign fn_d = {in_d_i[DATA_W-2:0], in_d_i[DATA_W-1]} + DATA_W'(IDX + 1);

  scc_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_out_gen (.d_i(fn_d), .c_o(fn_c));

  // data and check bits captured on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_d_o <= '0;
      q_c_o <= '0;
    end else begin
      q_d_o <= fn_d;
      q_c_o <= fn_c;
    end
  end
endmodule

// File: rtl/scc_err_log.sv
module scc_err_log #(
  parameter int unsigned NUM_FLAGS = scc_pkg::DEF_STAGES + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] fail_i,
  input  logic                 clr_i,
  output logic [NUM_FLAGS-1:0] err_o
);
  // new fails win over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= '0;
    else         err_o <= (clr_i ? '0 : err_o) | fail_i;
  end
endmodule

// File: rtl/scc_chain.sv
module scc_chain #(
  parameter int unsigned NUM_STAGES = scc_pkg::DEF_STAGES,
  parameter int unsigned DATA_W     = scc_pkg::DEF_DATA_W,
  parameter int unsigned CHK_W      = scc_pkg::DEF_CHK_W,
  localparam int unsigned LINK_W    = DATA_W + CHK_W,
  localparam int unsigned INJ_W     = NUM_STAGES * LINK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     data_i,
  input  logic [CHK_W-1:0]      chk_i,
  input  logic [INJ_W-1:0]      inj_i,
  input  logic                  clr_i,
  output logic [DATA_W-1:0]     data_o,
  output logic [CHK_W-1:0]      chk_o,
  output logic [NUM_STAGES:0]   err_o,
  output logic                  err_any_o
);
  logic [DATA_W-1:0] link_d [NUM_STAGES+1];
  logic [CHK_W-1:0]  link_c [NUM_STAGES+1];
  logic [NUM_STAGES:0] fail_w;
  logic [CHK_W-1:0]  final_c;

  assign link_d[0] = data_i;
  assign link_c[0] = chk_i;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [DATA_W-1:0] q_d;
    logic [CHK_W-1:0]  q_c;
    scc_stage #(.DATA_W(DATA_W), .CHK_W(CHK_W), .IDX(s)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_d_i (link_d[s]),
      .in_c_i (link_c[s]),
      .fail_o (fail_w[s]),
      .q_d_o  (q_d),
      .q_c_o  (q_c)
    );
    assign link_d[s+1] = q_d ^ inj_i[s*LINK_W +: DATA_W];
    assign link_c[s+1] = q_c ^ inj_i[s*LINK_W + DATA_W +: CHK_W];
  end

  // final checker covers the last stage and the output nets
  scc_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_final_chk (
    .d_i (link_d[NUM_STAGES]),
    .c_o (final_c)
  );
  assign fail_w[NUM_STAGES] = (final_c != link_c[NUM_STAGES]);

  scc_err_log #(.NUM_FLAGS(NUM_STAGES + 1)) u_err_log (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fail_i (fail_w),
    .clr_i  (clr_i),
    .err_o  (err_o)
  );

  assign err_any_o = |err_o;
  assign data_o    = link_d[NUM_STAGES];
  assign chk_o     = link_c[NUM_STAGES];
endmodule

// File: rtl/scc_chain_chk.sv
module scc_chain_chk #(
  parameter int unsigned NUM_STAGES = scc_pkg::DEF_STAGES,
  parameter int unsigned DATA_W     = scc_pkg::DEF_DATA_W,
  parameter int unsigned CHK_W      = scc_pkg::DEF_CHK_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clr_i,
  input logic [NUM_STAGES:0]        fail_i,
  input logic [NUM_STAGES:0]        err_i,
  input logic [DATA_W+CHK_W-1:0]    inj_last_i,
  input logic [DATA_W-1:0]          data_i,
  input logic [CHK_W-1:0]           chk_i
);
  logic [CHK_W-1:0] ref_c;
  scc_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ref (.d_i(data_i), .c_o(ref_c));

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_i & $past(err_i)) == $past(err_i)));

  // R5
  fail_recorded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i != '0) |=> ((err_i & $past(fail_i)) == $past(fail_i)));

  // R8
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && fail_i == '0) |=> (err_i == '0));

  // R3
  out_coherent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_last_i == '0) |-> (chk_i == ref_c));
endmodule

bind scc_chain scc_chain_chk #(
  .NUM_STAGES (NUM_STAGES),
  .DATA_W     (DATA_W),
  .CHK_W      (CHK_W)
) u_chain_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .fail_i     (fail_w),
  .err_i      (err_o),
  .inj_last_i (inj_i[NUM_STAGES*(DATA_W+CHK_W)-1 -: DATA_W+CHK_W]),
  .data_i     (data_o),
  .chk_i      (chk_o)
);

// File: tb/scc_chain_tb.sv
module scc_chain_tb;
  localparam int N  = 3;
  localparam int W  = 8;
  localparam int C  = 4;
  localparam int LW = W + C;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [C-1:0] chk_i = '0;
  logic [N*LW-1:0] inj = '0;
  logic clr = 1'b0;
  logic [W-1:0] data_o;
  logic [C-1:0] chk_o;
  logic [N:0] err_o;
  logic err_any_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  scc_chain #(.NUM_STAGES(N), .DATA_W(W), .CHK_W(C)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .chk_i(chk_i),
    .inj_i(inj), .clr_i(clr), .data_o(data_o), .chk_o(chk_o),
    .err_o(err_o), .err_any_o(err_any_o)
  );

  function automatic logic [C-1:0] gen_b(input logic [W-1:0] d);
    logic [C-1:0] c = '0;
    for (int k = 0; k < C; k++)
      for (int i = 0; i < W; i++)
        if (k == 0 || ((i >> (k - 1)) % 2 == 1)) c[k] ^= d[i];
    return c;
  endfunction

  function automatic logic [W-1:0] chain_b(input logic [W-1:0] d);
    logic [W-1:0] x = d;
    for (int s = 0; s < N; s++) x = {x[W-2:0], x[W-1]} + W'(s + 1);
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_inj(input int j, input logic [W-1:0] ed, input logic [C-1:0] ec);
    inj[(j-1)*LW +: LW] = {ec, ed};
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hist [0:63];
    logic [W-1:0] ed;
    logic [C-1:0] ec;
    logic [N:0] exp_e;
    void'($urandom(32'd4242));

    // R10 reset state
    #35;
    check("R10 err", 32'(err_o), 0);
    check("R10 any", 32'(err_any_o), 0);
    check("R10 data", 32'(data_o), 0);
    check("R10 chk", 32'(chk_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2/R3 random stream with coherent pairs
    for (int cyc = 0; cyc < 48; cyc++) begin
      @(negedge clk);
      if (cyc >= N) check("R2 data", 32'(data_o), 32'(chain_b(hist[cyc-N])));
      check("R3 chk", 32'(chk_o), 32'(gen_b(data_o)));
      hist[cyc] = W'($urandom);
      data_i = hist[cyc];
      chk_i = gen_b(hist[cyc]);
    end
    @(negedge clk);
    check("R1 no false flag", 32'(err_o), 0);

    // R4 bad input pair, then R7 sticky, R9 any
    chk_i = gen_b(data_i) ^ 4'h2;
    @(negedge clk);
    chk_i = gen_b(data_i);
    check("R4 input mismatch", 32'(err_o), 1);
    check("R9 any set", 32'(err_any_o), 1);
    repeat (3) @(negedge clk);
    check("R7 sticky", 32'(err_o), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8 clear", 32'(err_o), 0);
    check("R9 any clear", 32'(err_any_o), 0);

    // R5/R6 random link injections, first trial an undetectable codeword
    for (int j = 1; j <= N; j++) begin
      for (int t = 0; t < 5; t++) begin
        if (t == 0) begin ed = 8'h01; ec = gen_b(8'h01); end
        else begin ed = W'($urandom); ec = C'($urandom); end
        exp_e = (gen_b(ed) != ec) ? (N+1)'(1) << j : '0;
        set_inj(j, ed, ec);
        @(negedge clk);
        inj = '0;
        check(j == N ? "R6 final link" : "R5 link", 32'(err_o), 32'(exp_e));
        if (t == 0) check("R1 codeword mask", 32'(err_o), 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R8 clear after inj", 32'(err_o), 0);
      end
    end

    // R6 directed single data bit flip on last link
    set_inj(N, 8'h80, 4'h0);
    @(negedge clk);
    inj = '0;
    check("R6 data flip", 32'(err_o), 32'(1 << N));

    // R8 clear with new mismatch in same cycle
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    set_inj(2, 8'h00, 4'h1);
    @(negedge clk);
    inj = '0;
    check("R5 link2", 32'(err_o), 32'h4);
    clr = 1'b1;
    chk_i = gen_b(data_i) ^ 4'h8;
    @(negedge clk);
    clr = 1'b0;
    chk_i = gen_b(data_i);
    check("R8 set wins over clear", 32'(err_o), 32'h1);

    // R5 two links at once
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    set_inj(1, 8'h00, 4'h4);
    set_inj(N, 8'h00, 4'h1);
    @(negedge clk);
    inj = '0;
    check("R5 two links", 32'(err_o), 32'h2 | 32'(1 << N));
    @(negedge clk);
    check("R7 hold two", 32'(err_o), 32'h2 | 32'(1 << N));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule